// File: doc/BRIEF.md
# Configurable Width CRC Engine

This block computes a cyclic redundancy check over a byte stream, one byte per clock. Software sets the check width (8, 16, 24 or 32 bits), the generator polynomial, the starting register value, the final XOR mask and the ordering rules through a small write-only configuration port. Frame logic marks the first byte with a start strobe, presents the payload with a valid strobe, and marks the last payload byte with an end strobe.

The end strobe triggers one of two modes. In generate mode the engine emits the finished check value as W/8 bytes on consecutive cycles, so a transmitter can append them. In check mode the next W/8 valid bytes are taken as the received check value and compared with the computed one. A done pulse and a mismatch flag then appear. A start strobe restarts the computation at any time, so one frame can carry several independently protected sections.

Top module: `crc_engine`

## Requirements
- R1: After reset the engine uses a 32-bit width, polynomial 0x04C11DB7, a start value of all ones, an XOR mask of all ones, most-significant-bit-first input, no output reflection, most-significant-byte-first emission and generate mode. With these settings the nine ASCII bytes "123456789" give 0xFC891918.
- R2: Configuration register 3 holds the control fields. Bits [1:0] select the width: 0 selects 8 bits, 1 selects 16, 2 selects 24 and 3 selects 32. In generate mode crc_out_valid is high for exactly W/8 consecutive cycles, and the first of those cycles follows the cycle that accepted the end strobe.
- R3: Register 0 holds the polynomial, and its low W bits are used. For example, a 16-bit width with polynomial 0x1021, start value 0xFFFF and mask 0 gives 0x29B1 over "123456789". An 8-bit width with polynomial 0x07 and start value 0 gives 0xF4.
- R4: When control bit 2 is set, each input byte is fed bit 0 first. When it is clear, bit 7 is fed first.
- R5: When control bit 3 is set, the low W bits of the register are bit-reversed before the XOR mask (register 2) is applied. A full 32-bit reflected configuration gives 0xCBF43926 over "123456789".
- R6: When control bit 4 is set, the check value is emitted or compared least significant byte first. Otherwise it is most significant byte first.
- R7: When control bit 5 is set (check mode), check_done pulses for one cycle, the cycle after the last received check byte is consumed. On a match, mismatch is low in that cycle.
- R8: In check mode, if any received check byte differs from the computed one, mismatch is high together with check_done.
- R9: A start strobe in the middle of a frame discards all earlier bytes. The next result depends only on the bytes from that strobe onward.
- R10: A byte presented in the same cycle as the start strobe is processed on top of the start value (register 1).
- R11: Bits of the polynomial, start value and XOR mask above the selected width have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Register select: 0 polynomial, 1 start value, 2 XOR mask, 3 control |
| cfg_wdata | input | 32 | Configuration write data |
| sof | input | 1 | Start strobe, which restarts the computation |
| din_valid | input | 1 | Input byte valid |
| din | input | 8 | Input byte (payload or received check byte) |
| eof | input | 1 | End strobe, which marks the last payload byte or stands alone |
| crc_out_valid | output | 1 | Emitted check byte valid |
| crc_out_byte | output | 8 | Emitted check byte |
| check_done | output | 1 | One-cycle pulse when a comparison finishes |
| mismatch | output | 1 | Comparison failed, valid with check_done |
| busy | output | 1 | Emitting or waiting for check bytes |

## Verification
The bench anchors its own model with published check values for 8-, 16- and 32-bit settings. Getting the input bit order, output reflection or byte order wrong shifts those known values or reverses the emitted byte sequence. Writing junk into bits above the selected width catches a design that forgets to mask, because that design produces a different residue. A restart in the middle of a frame, with a byte in the same cycle, catches an engine that keeps earlier history or drops the first byte. Check mode is exercised with both correct and single-byte-corrupted trailers, so a flag that comes a cycle late or never fires is reported.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int CRC_MAX_W = 32;
  localparam int BYTE_W    = 8;
  localparam int NB_MAX    = CRC_MAX_W / BYTE_W;
  localparam int IDX_W     = $clog2(NB_MAX);

  typedef logic [CRC_MAX_W-1:0] crc_t;
  typedef logic [IDX_W-1:0]     wsel_t;

  typedef enum logic [1:0] {ST_IDLE, ST_EMIT, ST_CHECK} seq_st_e;

  typedef struct packed {
    logic  chk_mode;
    logic  out_lsbyte;
    logic  out_refl;
    logic  in_lsb;
    wsel_t wsel;
  } ctrl_t;

  function automatic int width_bits(input wsel_t s);
    return (int'(s) + 1) * BYTE_W;
  endfunction

  function automatic crc_t width_mask(input wsel_t s);
    crc_t m;
    m = '0;
    for (int i = 0; i < CRC_MAX_W; i++)
      if (i < width_bits(s)) m[i] = 1'b1;
    return m;
  endfunction

  function automatic crc_t crc_step(input crc_t cur, input logic [BYTE_W-1:0] b,
                                    input crc_t poly, input wsel_t s, input logic lsb_first);
    crc_t r;
    crc_t m;
    logic bit_in;
    logic fb;
    int   top;
    r   = cur;
    m   = width_mask(s);
    top = width_bits(s) - 1;
    for (int i = 0; i < BYTE_W; i++) begin
      bit_in = lsb_first ? b[i] : b[BYTE_W-1-i];
      fb     = r[top] ^ bit_in;
      r      = (r << 1) & m;
      if (fb) r = r ^ (poly & m);
    end
    return r;
  endfunction

  function automatic crc_t reflect_w(input crc_t v, input wsel_t s);
    crc_t r;
    int   wb;
    r  = '0;
    wb = width_bits(s);
    for (int i = 0; i < CRC_MAX_W; i++)
      if (i < wb) r[wb-1-i] = v[i];
    return r;
  endfunction
endpackage

// File: rtl/crc_cfg_regs.sv
module crc_cfg_regs
  import crc_pkg::*;
#(
  parameter crc_t DEF_POLY = 32'h04C1_1DB7,
  parameter crc_t DEF_INIT = 32'hFFFF_FFFF,
  parameter crc_t DEF_XOR  = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output crc_t        poly_q,
  output crc_t        init_q,
  output crc_t        xor_q,
  output ctrl_t       ctrl_q
);
  localparam int CTRL_W = $bits(ctrl_t);
  localparam ctrl_t CTRL_RST = '{chk_mode: 1'b0, out_lsbyte: 1'b0, out_refl: 1'b0,
                                 in_lsb: 1'b0, wsel: wsel_t'(NB_MAX-1)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poly_q <= DEF_POLY;
      init_q <= DEF_INIT;
      xor_q  <= DEF_XOR;
      ctrl_q <= CTRL_RST;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0:    poly_q <= cfg_wdata;
        2'd1:    init_q <= cfg_wdata;
        2'd2:    xor_q  <= cfg_wdata;
        default: ctrl_q <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
      endcase
    end
  end
endmodule

// File: rtl/crc_datapath.sv
module crc_datapath
  import crc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              feed,
  input  logic [BYTE_W-1:0] din,
  input  crc_t              poly_q,
  input  crc_t              init_q,
  input  crc_t              xor_q,
  input  ctrl_t             ctrl_q,
  output crc_t              crc_state,
  output crc_t              crc_final
);
  crc_t base;
  crc_t nxt;
  crc_t shaped;

  always_comb begin
    base = restart ? (init_q & width_mask(ctrl_q.wsel)) : crc_state;
    nxt  = feed ? crc_step(base, din, poly_q, ctrl_q.wsel, ctrl_q.in_lsb) : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_state <= '0;
    else        crc_state <= nxt;
  end

  always_comb begin
    shaped    = ctrl_q.out_refl ? reflect_w(crc_state, ctrl_q.wsel) : crc_state;
    crc_final = (shaped ^ xor_q) & width_mask(ctrl_q.wsel);
  end
endmodule

// File: rtl/crc_seq.sv
module crc_seq
  import crc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof,
  input  logic              din_valid,
  input  logic [BYTE_W-1:0] din,
  input  logic              eof,
  input  ctrl_t             ctrl_q,
  input  crc_t              crc_final,
  output logic              restart,
  output logic              feed,
  output logic              crc_out_valid,
  output logic [BYTE_W-1:0] crc_out_byte,
  output logic              check_done,
  output logic              mismatch,
  output logic              busy
);
  seq_st_e            st_q;
  wsel_t              idx_q;
  logic               err_q;
  wsel_t              bsel;
  logic [BYTE_W-1:0]  exp_byte;
  logic               byte_ne;
  logic               open_win;
  logic               last_idx;

  assign restart  = sof;
  assign open_win = sof || (st_q == ST_IDLE);
  assign feed     = din_valid && open_win;
  assign last_idx = (idx_q == ctrl_q.wsel);

  always_comb begin
    bsel     = ctrl_q.out_lsbyte ? idx_q : wsel_t'(ctrl_q.wsel - idx_q);
    exp_byte = crc_final[bsel*BYTE_W +: BYTE_W];
    byte_ne  = (din != exp_byte);
  end

  assign crc_out_valid = (st_q == ST_EMIT);
  assign crc_out_byte  = crc_out_valid ? exp_byte : '0;
  assign busy          = (st_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      idx_q      <= '0;
      err_q      <= 1'b0;
      check_done <= 1'b0;
      mismatch   <= 1'b0;
    end else begin
      check_done <= 1'b0;
      mismatch   <= 1'b0;
      if (open_win) begin
        idx_q <= '0;
        err_q <= 1'b0;
        if (eof) st_q <= ctrl_q.chk_mode ? ST_CHECK : ST_EMIT;
        else     st_q <= ST_IDLE;
      end else if (st_q == ST_EMIT) begin
        if (last_idx) st_q <= ST_IDLE;
        else          idx_q <= idx_q + 1'b1;
      end else if (st_q == ST_CHECK && din_valid) begin
        if (last_idx) begin
          st_q       <= ST_IDLE;
          check_done <= 1'b1;
          mismatch   <= err_q | byte_ne;
        end else begin
          idx_q <= idx_q + 1'b1;
          err_q <= err_q | byte_ne;
        end
      end
    end
  end
endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_pkg::*;
#(
  parameter logic [31:0] DEF_POLY = 32'h04C1_1DB7,
  parameter logic [31:0] DEF_INIT = 32'hFFFF_FFFF,
  parameter logic [31:0] DEF_XOR  = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic        sof,
  input  logic        din_valid,
  input  logic [7:0]  din,
  input  logic        eof,
  output logic        crc_out_valid,
  output logic [7:0]  crc_out_byte,
  output logic        check_done,
  output logic        mismatch,
  output logic        busy
);
  crc_t  poly_q, init_q, xor_q, crc_state, crc_final;
  ctrl_t ctrl_q;
  logic  restart, feed;

  crc_cfg_regs #(.DEF_POLY(DEF_POLY), .DEF_INIT(DEF_INIT), .DEF_XOR(DEF_XOR)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .poly_q(poly_q), .init_q(init_q), .xor_q(xor_q), .ctrl_q(ctrl_q)
  );

  crc_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .restart(restart), .feed(feed), .din(din),
    .poly_q(poly_q), .init_q(init_q), .xor_q(xor_q), .ctrl_q(ctrl_q),
    .crc_state(crc_state), .crc_final(crc_final)
  );

  crc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .sof(sof), .din_valid(din_valid), .din(din), .eof(eof),
    .ctrl_q(ctrl_q), .crc_final(crc_final), .restart(restart), .feed(feed),
    .crc_out_valid(crc_out_valid), .crc_out_byte(crc_out_byte),
    .check_done(check_done), .mismatch(mismatch), .busy(busy)
  );
endmodule

// File: rtl/crc_engine_chk.sv
module crc_engine_chk
  import crc_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  sof,
  input logic  din_valid,
  input logic  cfg_we,
  input logic  crc_out_valid,
  input logic  check_done,
  input logic  mismatch,
  input crc_t  crc_state,
  input crc_t  init_q,
  input ctrl_t ctrl_q
);
  logic [IDX_W:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             run_q <= '0;
    else if (crc_out_valid) run_q <= run_q + 1'b1;
    else                    run_q <= '0;
  end

  // R2: never more than W/8 emitted bytes in a row
  p_emit_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    crc_out_valid |-> (run_q <= {1'b0, ctrl_q.wsel}));

  // R2: emission only happens in generate mode
  p_emit_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    crc_out_valid |-> !ctrl_q.chk_mode);

  // R7: done is a single-cycle pulse following a consumed byte
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    check_done |=> !check_done);
  p_done_after_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    check_done |-> $past(din_valid));

  // R8: mismatch only reported with done
  p_mismatch_qual_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |-> check_done);

  // R9: a bare restart loads the masked start value
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && !din_valid && !cfg_we) |=>
      (crc_state == ($past(init_q) & width_mask($past(ctrl_q.wsel)))));
endmodule

bind crc_engine crc_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sof(sof), .din_valid(din_valid), .cfg_we(cfg_we),
  .crc_out_valid(crc_out_valid), .check_done(check_done), .mismatch(mismatch),
  .crc_state(crc_state), .init_q(init_q), .ctrl_q(ctrl_q)
);

// File: tb/crc_engine_tb.sv
module crc_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        sof = 1'b0, din_valid = 1'b0, eof = 1'b0;
  logic [7:0]  din = '0;
  logic        crc_out_valid, check_done, mismatch, busy;
  logic [7:0]  crc_out_byte;

  int n_chk = 0;
  int n_bad = 0;

  // model configuration
  int          m_w;
  logic [31:0] m_poly, m_init, m_xor;
  bit          m_inlsb, m_refl, m_lsbyte, m_chk;
  logic [7:0]  msg [0:15];
  int          mlen;

  always #10 clk = ~clk;

  crc_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .sof(sof), .din_valid(din_valid), .din(din), .eof(eof),
    .crc_out_valid(crc_out_valid), .crc_out_byte(crc_out_byte),
    .check_done(check_done), .mismatch(mismatch), .busy(busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  // independent reference: bit list, then a long-arithmetic shift register
  function automatic logic [31:0] model_crc();
    longint unsigned r, top, msk, p;
    logic [31:0] res;
    bit b;
    msk = (64'd1 << m_w) - 1;
    top = 64'd1 << (m_w - 1);
    r   = m_init & msk;
    p   = m_poly & msk;
    for (int k = 0; k < mlen; k++)
      for (int j = 0; j < 8; j++) begin
        b = m_inlsb ? msg[k][j] : msg[k][7-j];
        if (((r & top) != 0) != b) r = ((r << 1) & msk) ^ p;
        else                        r = (r << 1) & msk;
      end
    res = 32'(r);
    if (m_refl) begin
      logic [31:0] t;
      t = '0;
      for (int j = 0; j < m_w; j++) t[m_w-1-j] = res[j];
      res = t;
    end
    return (res ^ m_xor) & 32'(msk);
  endfunction

  function automatic logic [7:0] nth_byte(input logic [31:0] v, input int k);
    int pos;
    pos = m_lsbyte ? k : (m_w/8 - 1 - k);
    return v[pos*8 +: 8];
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic apply_cfg();
    wr(2'd0, m_poly);
    wr(2'd1, m_init);
    wr(2'd2, m_xor);
    wr(2'd3, {26'd0, m_chk, m_lsbyte, m_refl, m_inlsb, 2'(m_w/8 - 1)});
  endtask

  task automatic load_digits();
    for (int k = 0; k < 9; k++) msg[k] = 8'h31 + 8'(k);
    mlen = 9;
  endtask

  task automatic send_msg();
    for (int k = 0; k < mlen; k++) begin
      @(negedge clk);
      sof = (k == 0); din_valid = 1'b1; din = msg[k]; eof = (k == mlen - 1);
    end
  endtask

  // generate mode: collect and compare emitted bytes
  task automatic gen_frame(input string req, input logic [31:0] exp);
    logic [31:0] got;
    int cnt;
    got = '0; cnt = 0;
    send_msg();
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      sof = 1'b0; din_valid = 1'b0; eof = 1'b0;
      if (crc_out_valid) begin
        if (cnt < 4) got[(m_lsbyte ? cnt : (m_w/8 - 1 - cnt))*8 +: 8] = crc_out_byte;
        cnt++;
      end
    end
    check({req, " value"}, got, exp);
    check("R2 emitted byte count", 32'(cnt), 32'(m_w/8));
  endtask

  // check mode: present trailer, optionally corrupting one byte
  task automatic chk_frame(input string req, input logic [31:0] crcv, input int bad_k);
    send_msg();
    for (int k = 0; k < m_w/8; k++) begin
      @(negedge clk);
      sof = 1'b0; eof = 1'b0; din_valid = 1'b1;
      din = nth_byte(crcv, k) ^ ((k == bad_k) ? 8'h5A : 8'h00);
      check("R7 no early done", 32'(check_done), 32'd0);
    end
    @(negedge clk);
    din_valid = 1'b0;
    check({req, " done"}, 32'(check_done), 32'd1);
    check({req, " mismatch"}, 32'(mismatch), 32'(bad_k >= 0));
    @(negedge clk);
    check("R7 done one cycle", 32'(check_done), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset idle", {29'd0, crc_out_valid, check_done, busy}, 32'd0);

    // R1: defaults untouched
    m_w = 32; m_poly = 32'h04C11DB7; m_init = '1; m_xor = '1;
    m_inlsb = 0; m_refl = 0; m_lsbyte = 0; m_chk = 0;
    load_digits();
    check("R1 model anchor", model_crc(), 32'hFC891918);
    gen_frame("R1 default crc", 32'hFC891918);

    // R3: 16-bit poly 0x1021, junk above width also covers R11
    m_w = 16; m_poly = 32'hABCD1021; m_init = 32'h1234FFFF; m_xor = 32'hFFFF0000;
    apply_cfg();
    gen_frame("R3 R11 crc16 masked", 32'h29B1);

    // R3: 8-bit
    m_w = 8; m_poly = 32'h07; m_init = 0; m_xor = 0;
    apply_cfg();
    gen_frame("R3 crc8", 32'hF4);

    // R4 R5: fully reflected 32-bit
    m_w = 32; m_poly = 32'h04C11DB7; m_init = '1; m_xor = '1; m_inlsb = 1; m_refl = 1;
    apply_cfg();
    gen_frame("R4 R5 reflected crc32", 32'hCBF43926);

    // R6: least significant byte first, 16-bit reflected, check first byte directly
    m_w = 16; m_poly = 32'h1021; m_init = 0; m_xor = 0; m_lsbyte = 1;
    apply_cfg();
    send_msg();
    @(negedge clk);
    sof = 0; din_valid = 0; eof = 0;
    check("R6 first byte is low byte", {24'd0, crc_out_byte}, 32'h89);
    @(negedge clk);
    check("R6 second byte is high byte", {24'd0, crc_out_byte}, 32'h21);
    repeat (2) @(negedge clk);

    // R9 R10: restart mid-frame with a byte on the strobe cycle
    m_w = 32; m_poly = 32'h04C11DB7; m_init = '1; m_xor = '1;
    m_inlsb = 0; m_refl = 0; m_lsbyte = 0;
    apply_cfg();
    @(negedge clk); sof = 1; din_valid = 1; din = 8'hA5; eof = 0;
    @(negedge clk); sof = 0; din = 8'h3C;
    gen_frame("R9 R10 restart", 32'hFC891918);

    // R7 R8: check mode with good and corrupted trailers
    m_chk = 1;
    apply_cfg();
    chk_frame("R7 match", 32'hFC891918, -1);
    chk_frame("R8 corrupt", 32'hFC891918, 2);

    // randomized configurations and frames
    for (int t = 0; t < 40; t++) begin
      int bad;
      m_w      = 8 * (int'($urandom % 4) + 1);
      m_poly   = $urandom | 32'h1;
      m_init   = $urandom;
      m_xor    = $urandom;
      m_inlsb  = 1'($urandom);
      m_refl   = 1'($urandom);
      m_lsbyte = 1'($urandom);
      m_chk    = 1'($urandom);
      mlen     = int'($urandom % 12) + 1;
      for (int k = 0; k < mlen; k++) msg[k] = 8'($urandom);
      apply_cfg();
      if (m_chk) begin
        bad = ($urandom % 2 == 0) ? -1 : int'($urandom % (m_w/8));
        chk_frame("R7 R8 random check", model_crc(), bad);
      end else begin
        gen_frame("R2 R4 R5 R6 random gen", model_crc());
      end
    end
    finish_up();
  end
endmodule